// File: doc/BRIEF.md
# GPIO Bank Controller with Pin Interrupts

This block controls a bank of general-purpose pins arranged as ports of equal width (four ports of eight pins by default). Software reaches it over a simple valid/write/address/data register bus. Each port has its own set of registers: pin mode, output enable, output value, a synchronized view of the pad inputs, interrupt status, interrupt enable and interrupt sense selection, plus a write-one-to-clear strobe. A pin in GPIO mode drives its pad from these registers. A pin in special-function mode passes an alternate function's output and enable straight to the pad.

Every pin has a lock bit. Once set, it freezes that pin's mode, output controls and interrupt sense until the next reset. A second address window accepts masked writes. In that window the upper byte of the write data chooses which pins the lower byte updates, so software can change single pins without a read-modify-write.

Each pin can raise an interrupt on a level, a single edge or either edge. The pin's status bits are combined with the enable bits into one registered interrupt line.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset, the mode, lock, output enable, output value, interrupt enable and sense registers all read 0, and irq is 0. With mode 0, pad_out and pad_oe follow alt_out and alt_oe. The default sense is low-level, so a pin held at 0 shows status 1.
- R2: Word address bit 5 selects the masked window. Bits [4:2] select the register: 0 config, 1 output enable, 2 output value, 3 input, 4 status, 5 interrupt enable, 6 sense, 7 clear. Bits [1:0] select the port. A read issued in one cycle returns its data on bus_rdata, with bus_rvalid high, in the next cycle. Writes do not raise bus_rvalid.
- R3: Config bits [7:0] hold the pin modes (1 = GPIO, 0 = special function) and bits [15:8] hold the lock bits. A plain-window write ORs its bits [15:8] into the lock bits. No write ever clears a lock bit.
- R4: For a pin whose lock bit was set before the write, writes to its mode, output enable, output value and sense fields are ignored. Interrupt enable and clear are still accepted.
- R5: In the masked window, a write changes only the pins whose bit in data[15:8] is 1, taking their new value from data[7:0]. A masked config write touches only the modes and never the locks. A masked sense write touches only the polarity field. A read in the masked window returns the same value as in the plain window.
- R6: pad_out and pad_oe are registered. They show output value and output enable for GPIO-mode pins, and alt_out and alt_oe for special-function pins, one cycle after the inputs to that selection change.
- R7: The input register returns each pad level after a two-flop synchronizer, whatever the output enable setting.
- R8: The sense register holds three fields per pin n. Bit n is polarity (1 = high or rising). Bit n+8 selects edge (1) or level (0) sensing. Bit n+16 makes an edge-sensed pin trigger on both edges.
- R9: An edge-sensed status bit is set by the selected edge and stays set until cleared. A level-sensed status bit follows the pin's active level. Status reflects a pad change on the third clock edge after it.
- R10: Writing 1 to a clear bit clears an edge-sensed status bit, and writing 0 has no effect. If a new edge arrives in the same cycle as the clear, the edge wins. A clear has no lasting effect on a level-sensed bit.
- R11: irq is a register holding the OR, over all pins, of status AND interrupt enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Bus access request |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | $clog2(NUM_PORTS)+4 | Word address: window, register, port |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, one cycle after the read |
| bus_rvalid | output | 1 | Read data valid |
| pad_in | input | NUM_PORTS*PORT_PINS | Pad input levels (asynchronous) |
| pad_out | output | NUM_PORTS*PORT_PINS | Pad output value |
| pad_oe | output | NUM_PORTS*PORT_PINS | Pad output enable |
| alt_out | input | NUM_PORTS*PORT_PINS | Special-function output value |
| alt_oe | input | NUM_PORTS*PORT_PINS | Special-function output enable |
| irq | output | 1 | Combined interrupt |

## Verification
A write takes effect at the clock edge that accepts it, so a read issued in the next cycle sees it, and its pad result appears one edge later. A pad change reaches the input register after two edges and the status bits after three, and irq follows one edge after that. The bench waits exactly those counts before it samples, and it checks irq both one cycle early (still low) and on time. The clear-versus-edge race is forced by timing a clear write to land on the third edge after a pin change.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  // Register selector within a port; the encoding is the address field.
  typedef enum logic [2:0] {
    REG_CFG  = 3'd0,
    REG_OE   = 3'd1,
    REG_OUT  = 3'd2,
    REG_IN   = 3'd3,
    REG_STAT = 3'd4,
    REG_IEN  = 3'd5,
    REG_LVL  = 3'd6,
    REG_CLR  = 3'd7
  } reg_type_e;

endpackage

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_bank_pkg::*;
#(
  parameter int PINS = 8,
  localparam int WD_W = 3 * PINS
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  reg_type_e       wr_type,
  input  logic            wr_masked,
  input  logic [WD_W-1:0] wr_data,
  output logic [PINS-1:0] mode,
  output logic [PINS-1:0] lock,
  output logic [PINS-1:0] oe,
  output logic [PINS-1:0] outv,
  output logic [PINS-1:0] ien,
  output logic [PINS-1:0] pol,
  output logic [PINS-1:0] edge_sel,
  output logic [PINS-1:0] both,
  output logic [PINS-1:0] clr_pulse
);

  logic [PINS-1:0] wmask;
  logic [PINS-1:0] wval;
  logic [PINS-1:0] upper;
  logic [PINS-1:0] top3;
  logic [PINS-1:0] open_bits;

  always_comb begin
    upper     = wr_data[2*PINS-1:PINS];
    top3      = wr_data[3*PINS-1:2*PINS];
    wval      = wr_data[PINS-1:0];
    wmask     = wr_masked ? upper : '1;
    // Lockable fields only accept pins that were unlocked before this write.
    open_bits = wmask & ~lock;
    clr_pulse = (wr_en && wr_type == REG_CLR) ? (wval & wmask) : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode     <= '0;
      lock     <= '0;
      oe       <= '0;
      outv     <= '0;
      ien      <= '0;
      pol      <= '0;
      edge_sel <= '0;
      both     <= '0;
    end else if (wr_en) begin
      case (wr_type)
        REG_CFG: begin
          mode <= (mode & ~open_bits) | (wval & open_bits);
          if (!wr_masked) lock <= lock | upper;
        end
        REG_OE:  oe   <= (oe & ~open_bits) | (wval & open_bits);
        REG_OUT: outv <= (outv & ~open_bits) | (wval & open_bits);
        REG_IEN: ien  <= (ien & ~wmask) | (wval & wmask);
        REG_LVL: begin
          pol <= (pol & ~open_bits) | (wval & open_bits);
          if (!wr_masked) begin
            edge_sel <= (edge_sel & ~open_bits) | (upper & open_bits);
            both     <= (both & ~open_bits) | (top3 & open_bits);
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit #(
  parameter int PINS = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PINS-1:0] pad_in,
  input  logic [PINS-1:0] pol,
  input  logic [PINS-1:0] edge_sel,
  input  logic [PINS-1:0] both,
  input  logic [PINS-1:0] clr,
  output logic [PINS-1:0] pin_sync,
  output logic [PINS-1:0] status
);

  logic [PINS-1:0] meta_q;
  logic [PINS-1:0] hist_q;
  logic [PINS-1:0] rise;
  logic [PINS-1:0] fall;
  logic [PINS-1:0] edge_hit;
  logic [PINS-1:0] lvl_hit;
  logic [PINS-1:0] status_d;

  always_comb begin
    rise     = pin_sync & ~hist_q;
    fall     = ~pin_sync & hist_q;
    edge_hit = (both & (rise | fall)) | (~both & pol & rise) | (~both & ~pol & fall);
    lvl_hit  = ~(pin_sync ^ pol);
    // Edge-sensed bits are sticky; a new edge overrides a clear.
    status_d = (edge_sel & ((status & ~clr) | edge_hit)) | (~edge_sel & lvl_hit);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q   <= '0;
      pin_sync <= '0;
      hist_q   <= '0;
      status   <= '0;
    end else begin
      meta_q   <= pad_in;
      pin_sync <= meta_q;
      hist_q   <= pin_sync;
      status   <= status_d;
    end
  end

endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux #(
  parameter int PINS = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PINS-1:0] mode,
  input  logic [PINS-1:0] gpio_out,
  input  logic [PINS-1:0] gpio_oe,
  input  logic [PINS-1:0] alt_out,
  input  logic [PINS-1:0] alt_oe,
  output logic [PINS-1:0] pad_out,
  output logic [PINS-1:0] pad_oe
);

  always_ff @(posedge clk) begin
    if (rst) begin
      pad_out <= '0;
      pad_oe  <= '0;
    end else begin
      pad_out <= (mode & gpio_out) | (~mode & alt_out);
      pad_oe  <= (mode & gpio_oe) | (~mode & alt_oe);
    end
  end

endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int PORT_PINS = 8,
  parameter int DATA_W    = 32,
  localparam int PORT_W   = $clog2(NUM_PORTS),
  localparam int ADDR_W   = PORT_W + 4,
  localparam int NUM_PINS = NUM_PORTS * PORT_PINS
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_valid,
  input  logic                bus_write,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  output logic                bus_rvalid,
  input  logic [NUM_PINS-1:0] pad_in,
  output logic [NUM_PINS-1:0] pad_out,
  output logic [NUM_PINS-1:0] pad_oe,
  input  logic [NUM_PINS-1:0] alt_out,
  input  logic [NUM_PINS-1:0] alt_oe,
  output logic                irq
);

  localparam int FIELD_W = 3 * PORT_PINS;

  reg_type_e             acc_type;
  logic [PORT_W-1:0]     acc_port;
  logic                  acc_masked;
  logic                  wr_req;
  logic                  unused_wdata;

  assign acc_type     = reg_type_e'(bus_addr[PORT_W+2:PORT_W]);
  assign acc_port     = bus_addr[PORT_W-1:0];
  assign acc_masked   = bus_addr[ADDR_W-1];
  assign wr_req       = bus_valid && bus_write;
  assign unused_wdata = ^bus_wdata[DATA_W-1:FIELD_W];

  logic [PORT_PINS-1:0] mode_p [NUM_PORTS];
  logic [PORT_PINS-1:0] lock_p [NUM_PORTS];
  logic [PORT_PINS-1:0] oe_p   [NUM_PORTS];
  logic [PORT_PINS-1:0] outv_p [NUM_PORTS];
  logic [PORT_PINS-1:0] ien_p  [NUM_PORTS];
  logic [PORT_PINS-1:0] pol_p  [NUM_PORTS];
  logic [PORT_PINS-1:0] edge_p [NUM_PORTS];
  logic [PORT_PINS-1:0] both_p [NUM_PORTS];
  logic [PORT_PINS-1:0] clr_p  [NUM_PORTS];
  logic [PORT_PINS-1:0] sync_p [NUM_PORTS];
  logic [PORT_PINS-1:0] stat_p [NUM_PORTS];

  logic [NUM_PINS-1:0] mode_all;
  logic [NUM_PINS-1:0] lock_all;
  logic [NUM_PINS-1:0] out_all;
  logic [NUM_PINS-1:0] ien_all;
  logic [NUM_PINS-1:0] edge_all;
  logic [NUM_PINS-1:0] clr_all;
  logic [NUM_PINS-1:0] status_all;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    localparam int LO = p * PORT_PINS;

    gpio_port_regs #(.PINS(PORT_PINS)) u_regs (
      .clk       (clk),
      .rst       (rst),
      .wr_en     (wr_req && (acc_port == PORT_W'(p))),
      .wr_type   (acc_type),
      .wr_masked (acc_masked),
      .wr_data   (bus_wdata[FIELD_W-1:0]),
      .mode      (mode_p[p]),
      .lock      (lock_p[p]),
      .oe        (oe_p[p]),
      .outv      (outv_p[p]),
      .ien       (ien_p[p]),
      .pol       (pol_p[p]),
      .edge_sel  (edge_p[p]),
      .both      (both_p[p]),
      .clr_pulse (clr_p[p])
    );

    gpio_irq_unit #(.PINS(PORT_PINS)) u_irq (
      .clk      (clk),
      .rst      (rst),
      .pad_in   (pad_in[LO +: PORT_PINS]),
      .pol      (pol_p[p]),
      .edge_sel (edge_p[p]),
      .both     (both_p[p]),
      .clr      (clr_p[p]),
      .pin_sync (sync_p[p]),
      .status   (stat_p[p])
    );

    gpio_pad_mux #(.PINS(PORT_PINS)) u_pad (
      .clk      (clk),
      .rst      (rst),
      .mode     (mode_p[p]),
      .gpio_out (outv_p[p]),
      .gpio_oe  (oe_p[p]),
      .alt_out  (alt_out[LO +: PORT_PINS]),
      .alt_oe   (alt_oe[LO +: PORT_PINS]),
      .pad_out  (pad_out[LO +: PORT_PINS]),
      .pad_oe   (pad_oe[LO +: PORT_PINS])
    );

    assign mode_all[LO +: PORT_PINS]   = mode_p[p];
    assign lock_all[LO +: PORT_PINS]   = lock_p[p];
    assign out_all[LO +: PORT_PINS]    = outv_p[p];
    assign ien_all[LO +: PORT_PINS]    = ien_p[p];
    assign edge_all[LO +: PORT_PINS]   = edge_p[p];
    assign clr_all[LO +: PORT_PINS]    = clr_p[p];
    assign status_all[LO +: PORT_PINS] = stat_p[p];
  end

  logic [DATA_W-1:0] rd_word;

  always_comb begin
    rd_word = '0;
    case (acc_type)
      REG_CFG: begin
        rd_word[PORT_PINS-1:0]           = mode_p[acc_port];
        rd_word[2*PORT_PINS-1:PORT_PINS] = lock_p[acc_port];
      end
      REG_OE:   rd_word[PORT_PINS-1:0] = oe_p[acc_port];
      REG_OUT:  rd_word[PORT_PINS-1:0] = outv_p[acc_port];
      REG_IN:   rd_word[PORT_PINS-1:0] = sync_p[acc_port];
      REG_STAT: rd_word[PORT_PINS-1:0] = stat_p[acc_port];
      REG_IEN:  rd_word[PORT_PINS-1:0] = ien_p[acc_port];
      REG_LVL: begin
        rd_word[PORT_PINS-1:0]             = pol_p[acc_port];
        rd_word[2*PORT_PINS-1:PORT_PINS]   = edge_p[acc_port];
        rd_word[3*PORT_PINS-1:2*PORT_PINS] = both_p[acc_port];
      end
      default: rd_word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
      irq        <= 1'b0;
    end else begin
      bus_rvalid <= bus_valid && !bus_write;
      if (bus_valid && !bus_write) bus_rdata <= rd_word;
      irq <= |(status_all & ien_all);
    end
  end

endmodule

// File: rtl/gpio_bank_ctrl_chk.sv
module gpio_bank_ctrl_chk #(
  parameter int NUM_PINS = 32
) (
  input logic                clk,
  input logic                rst,
  input logic                irq,
  input logic [NUM_PINS-1:0] pad_out,
  input logic [NUM_PINS-1:0] alt_out,
  input logic [NUM_PINS-1:0] mode_all,
  input logic [NUM_PINS-1:0] out_all,
  input logic [NUM_PINS-1:0] lock_all,
  input logic [NUM_PINS-1:0] ien_all,
  input logic [NUM_PINS-1:0] edge_all,
  input logic [NUM_PINS-1:0] clr_all,
  input logic [NUM_PINS-1:0] status_all
);

  // R3: lock bits only ever gain ones
  p_lock_sticky_r3: assert property (@(posedge clk) disable iff (rst)
    (lock_all & $past(lock_all)) == $past(lock_all));

  // R4: a pin locked before a cycle keeps its mode through it
  p_locked_mode_r4: assert property (@(posedge clk) disable iff (rst)
    ((mode_all ^ $past(mode_all)) & $past(lock_all)) == '0);

  // R6: pad output is last cycle's mode-selected source
  p_pad_mux_r6: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> pad_out == $past((mode_all & out_all) | (~mode_all & alt_out)));

  // R9: an edge-sensed status bit drops only after a clear
  p_edge_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    ($past(status_all) & $past(edge_all) & edge_all & ~$past(clr_all) & ~status_all) == '0);

  // R11: irq is the registered OR of enabled status
  p_irq_or_r11: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> irq == $past(|(status_all & ien_all)));

endmodule

bind gpio_bank_ctrl gpio_bank_ctrl_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .irq        (irq),
  .pad_out    (pad_out),
  .alt_out    (alt_out),
  .mode_all   (mode_all),
  .out_all    (out_all),
  .lock_all   (lock_all),
  .ien_all    (ien_all),
  .edge_all   (edge_all),
  .clr_all    (clr_all),
  .status_all (status_all)
);

// File: tb/gpio_bank_ctrl_tb.sv
module gpio_bank_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] ALT_O = 32'h6C3A_B45D;
  localparam logic [31:0] ALT_E = 32'h1E87_B4C2;
  localparam logic [2:0] T_CFG = 3'd0, T_OE = 3'd1, T_OUT = 3'd2, T_IN = 3'd3,
                         T_STAT = 3'd4, T_IEN = 3'd5, T_LVL = 3'd6, T_CLR = 3'd7;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic [31:0] pad_in = '0;
  logic [31:0] pad_out, pad_oe;
  logic [31:0] alt_out = ALT_O;
  logic [31:0] alt_oe = ALT_E;
  logic        irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_bank_ctrl u_dut (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .alt_out(alt_out), .alt_oe(alt_oe), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic win, input logic [2:0] t, input int p, input logic [31:0] d);
    bus_valid = 1'b1; bus_write = 1'b1;
    bus_addr = {win, t, p[1:0]}; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic win, input logic [2:0] t, input int p, output logic [31:0] d);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = {win, t, p[1:0]};
    @(negedge clk);
    d = bus_rdata;
    bus_valid = 1'b0;
  endtask

  task automatic rdchk(input string tag, input logic win, input logic [2:0] t,
                       input int p, input logic [31:0] exp);
    logic [31:0] d;
    rd(win, t, p, d);
    chk(tag, d, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [7:0] cur, m, dv, v;
    settle(3);
    rst = 1'b0;
    settle(3);

    // R1: reset state
    for (int p = 0; p < 4; p++) begin
      rdchk("R1 cfg", 0, T_CFG, p, 0);
      rdchk("R1 oe", 0, T_OE, p, 0);
      rdchk("R1 out", 0, T_OUT, p, 0);
      rdchk("R1 ien", 0, T_IEN, p, 0);
      rdchk("R1 lvl", 0, T_LVL, p, 0);
      rdchk("R1 status low-level default", 0, T_STAT, p, 32'hFF);
      rdchk("R7 input at reset", 0, T_IN, p, 0);
      rdchk("R2 clear reads zero", 0, T_CLR, p, 0);
    end
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 pad_out alt", pad_out, ALT_O);
    chk("R1 pad_oe alt", pad_oe, ALT_E);
    rd(0, T_CFG, 0, d);
    chk("R2 rvalid after read", {31'b0, bus_rvalid}, 1);
    wr(0, T_IEN, 0, 0);
    chk("R2 rvalid after write", {31'b0, bus_rvalid}, 0);

    // R2/R6: output value and enable sweep on every port, GPIO mode
    for (int p = 0; p < 4; p++) wr(0, T_CFG, p, 32'h0000_00FF);
    for (int p = 0; p < 4; p++) begin
      for (int k = 0; k < 256; k++) begin
        v = k[7:0];
        wr(0, T_OUT, p, {24'b0, v});
        wr(0, T_OE, p, {24'b0, ~v});
        rdchk("R2 out readback", 0, T_OUT, p, {24'b0, v});
        rdchk("R2 oe readback", 0, T_OE, p, {24'b0, ~v});
        chk("R6 pad_out gpio", {24'b0, pad_out[p*8 +: 8]}, {24'b0, v});
        chk("R6 pad_oe gpio", {24'b0, pad_oe[p*8 +: 8]}, {24'b0, ~v});
      end
    end

    // R6: mode sweep on port 1 (out=93, oe=00 after sweep above)
    wr(0, T_OUT, 1, 32'h93);
    for (int k = 0; k < 256; k++) begin
      m = k[7:0];
      wr(0, T_CFG, 1, {24'b0, m});
      settle(1);
      chk("R6 pad_out mixed", {24'b0, pad_out[15:8]}, {24'b0, (8'h93 & m) | (ALT_O[15:8] & ~m)});
      chk("R6 pad_oe mixed", {24'b0, pad_oe[15:8]}, {24'b0, ALT_E[15:8] & ~m});
    end
    wr(0, T_CFG, 1, 32'hFF);

    // R5: masked window on port 2 output enable
    cur = 8'h00;
    for (int i = 0; i < 64; i++) begin
      m = 8'((i * 13) & 255);
      dv = 8'((i * 29 + 7) & 255);
      wr(1, T_OE, 2, {16'b0, m, dv});
      cur = (cur & ~m) | (dv & m);
      rdchk("R5 masked oe plain read", 0, T_OE, 2, {24'b0, cur});
      rdchk("R5 masked oe masked read", 1, T_OE, 2, {24'b0, cur});
    end
    wr(1, T_CFG, 2, 32'h0000_0F00);
    rdchk("R5 masked cfg modes only, no lock", 0, T_CFG, 2, 32'h0000_00F0);
    wr(1, T_CFG, 2, 32'h0000_FFFF);
    rdchk("R5 masked cfg restore", 0, T_CFG, 2, 32'h0000_00FF);
    wr(0, T_LVL, 2, 32'h00FF_FF00);
    rdchk("R8 sense fields", 0, T_LVL, 2, 32'h00FF_FF00);
    wr(1, T_LVL, 2, 32'h0000_0F05);
    rdchk("R5 masked sense polarity only", 0, T_LVL, 2, 32'h00FF_FF05);
    wr(1, T_IEN, 2, 32'h0000_F0AA);
    rdchk("R5 masked ien", 0, T_IEN, 2, 32'h0000_00A0);
    wr(0, T_IEN, 2, 0);

    // R3/R4: lock on port 3 (mode FF, oe 00, out FF)
    wr(0, T_CFG, 3, 32'h0000_0FFF);
    rdchk("R3 lock set", 0, T_CFG, 3, 32'h0000_0FFF);
    wr(0, T_OE, 3, 32'hFF);
    rdchk("R4 locked oe", 0, T_OE, 3, 32'hF0);
    wr(0, T_OUT, 3, 32'h00);
    rdchk("R4 locked out", 0, T_OUT, 3, 32'h0F);
    wr(0, T_CFG, 3, 32'h0000_0000);
    rdchk("R3 lock not cleared, R4 locked mode", 0, T_CFG, 3, 32'h0000_0F0F);
    wr(0, T_LVL, 3, 32'h00FF_FFFF);
    rdchk("R4 locked sense", 0, T_LVL, 3, 32'h00F0_F0F0);
    wr(1, T_OE, 3, 32'h0000_FF00);
    rdchk("R4 locked masked oe", 0, T_OE, 3, 32'h00);
    wr(0, T_CFG, 3, 32'h0000_3000);
    rdchk("R3 lock accumulates", 0, T_CFG, 3, 32'h0000_3F0F);
    wr(1, T_CFG, 3, 32'h0000_FF00);
    rdchk("R3 masked window cannot touch lock", 0, T_CFG, 3, 32'h0000_3F0F);
    settle(1);
    chk("R6 pad_out locked port", {24'b0, pad_out[31:24]},
        {24'b0, (8'h0F & 8'h0F) | (ALT_O[31:24] & 8'hF0)});
    wr(0, T_IEN, 3, 32'hFF);
    rdchk("R4 ien not lockable", 0, T_IEN, 3, 32'hFF);
    wr(0, T_IEN, 3, 0);

    // R8/R9/R10/R11: interrupts on port 0
    wr(0, T_LVL, 0, 32'h0004_0709);
    wr(0, T_CLR, 0, 32'hFF);
    wr(0, T_IEN, 0, 32'h0F);
    settle(2);
    rdchk("R9 idle status", 0, T_STAT, 0, 32'hF0);
    chk("R11 irq idle", {31'b0, irq}, 0);
    pad_in[0] = 1'b1;
    settle(3);
    chk("R11 irq not yet", {31'b0, irq}, 0);
    settle(1);
    chk("R11 irq on time", {31'b0, irq}, 1);
    rdchk("R9 rising edge", 0, T_STAT, 0, 32'hF1);
    pad_in[0] = 1'b0;
    settle(4);
    rdchk("R9 edge sticky", 0, T_STAT, 0, 32'hF1);
    wr(0, T_CLR, 0, 32'h00);
    rdchk("R10 write zero no effect", 0, T_STAT, 0, 32'hF1);
    wr(0, T_CLR, 0, 32'h01);
    settle(1);
    chk("R11 irq drops", {31'b0, irq}, 0);
    rdchk("R10 clear", 0, T_STAT, 0, 32'hF0);

    pad_in[1] = 1'b1;
    settle(4);
    rdchk("R8 falling ignores rise", 0, T_STAT, 0, 32'hF0);
    pad_in[1] = 1'b0;
    settle(4);
    rdchk("R8 falling edge", 0, T_STAT, 0, 32'hF2);
    wr(0, T_CLR, 0, 32'h02);

    pad_in[2] = 1'b1;
    settle(2);
    wr(0, T_CLR, 0, 32'h04);
    rdchk("R10 edge beats clear", 0, T_STAT, 0, 32'hF4);
    wr(0, T_CLR, 0, 32'h04);
    rdchk("R10 clear both-edge", 0, T_STAT, 0, 32'hF0);
    pad_in[2] = 1'b0;
    settle(4);
    rdchk("R8 both edges falling", 0, T_STAT, 0, 32'hF4);
    wr(0, T_CLR, 0, 32'h04);

    pad_in[3] = 1'b1;
    settle(3);
    rdchk("R9 level high", 0, T_STAT, 0, 32'hF8);
    wr(0, T_CLR, 0, 32'h08);
    rdchk("R10 clear on level bit", 0, T_STAT, 0, 32'hF8);
    pad_in[3] = 1'b0;
    settle(3);
    rdchk("R9 level follows", 0, T_STAT, 0, 32'hF0);
    chk("R11 irq with disabled status", {31'b0, irq}, 0);
    wr(0, T_IEN, 0, 32'h80);
    settle(1);
    chk("R11 irq enabled level", {31'b0, irq}, 1);
    wr(0, T_IEN, 0, 32'h00);
    settle(1);
    chk("R11 irq disabled", {31'b0, irq}, 0);

    // R7: input register sweep, independent of oe
    for (int p = 0; p < 4; p++) begin
      for (int k = 0; k < 16; k++) begin
        v = 8'((k * 53 + p * 17) & 255);
        pad_in[p*8 +: 8] = v;
        settle(2);
        rdchk("R7 input sync", 0, T_IN, p, {24'b0, v});
      end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule